// File: doc/BRIEF.md
# Watchdog Timer with Unlock-Pattern Restart

This block is a supervisory timer that pulls an internal reset when software stops servicing it. A free-running prescaler divides the clock by a power of two chosen through a 3-bit select field. Each prescaler tick decrements an 8-bit down counter. When a tick arrives while the counter is at zero, the counter reloads from a software-written reload value, a timeout flag is latched, and a reset pulse of fixed length is driven out.

Software restarts the count with a two-step unlock. It first writes the byte A5h to one feed register. Its very next register access must then be a write of 5Ah to a second feed register. Any other access in between, or a wrong second byte, discards the first step. An underflow changes only the timeout flag and the count. The prescaler select, the run bit and the reload value survive it, so software can read the flag after the restart to learn why the reset happened.

Top module: `wdog_core`

## Requirements
- R1: After reset, the control register at address 0 reads E4h (select field bits [7:5] = 111, run bit 2 = 1, timeout flag bit 1 = 0, other bits 0), the reload register reads RELOAD_RST, and the count reads RELOAD_RST.
- R2: Register addresses are: 0 control (read/write), 1 reload (read/write), 2 first feed (write) / current count (read), 3 second feed (write) / reads 00h.
- R3: While the run bit is 1, the count decrements once every 2^(PRESC_BASE+sel) clocks.
- R4: A prescaler tick while the count is 0 reloads the count from the reload register and sets the timeout flag.
- R5: `wd_reset` is high for exactly RST_LEN clocks, starting on the clock after the underflowing tick. A new underflow restarts the pulse.
- R6: An underflow leaves the select field, the run bit and the reload register unchanged.
- R7: A write of A5h to address 2, followed on the next register access by a write of 5Ah to address 3, loads the count from the reload register and restarts the prescaler phase. If a tick occurs in the same cycle, the load takes priority over that tick.
- R8: A second write other than 5Ah, or any read or write to any address between the two feed writes, cancels the pending feed, so the count is not reloaded.
- R9: While the run bit is 0, the prescaler and the count hold their values.
- R10: Writing 0 to control bit 1 clears the timeout flag. Writing 1 there has no effect. An underflow in the same cycle as a clearing write leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one access per cycle |
| reg_re | input | 1 | Register read strobe (counts as an access for the feed sequence) |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| wd_reset | output | 1 | Reset pulse raised by an underflow |

## Verification
The bench builds the block with PRESC_BASE = 0, RELOAD_RST = 30h and RST_LEN = 4. With these values a select of 0 gives one tick per clock and a select of 3 gives one tick every eight clocks. Underflows, back-to-back reset pulses and feeds racing a tick therefore all occur within a few dozen cycles instead of hundreds of thousands. Because the reload reset value is not all ones, a swapped or stuck reset value is visible on the first read.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int unsigned DW    = 8;
  localparam int unsigned AW    = 2;
  localparam int unsigned SEL_W = 3;

  localparam logic [AW-1:0] ADR_CTRL   = 2'd0;
  localparam logic [AW-1:0] ADR_RELOAD = 2'd1;
  localparam logic [AW-1:0] ADR_KEY1   = 2'd2;
  localparam logic [AW-1:0] ADR_KEY2   = 2'd3;

  localparam logic [DW-1:0] KEY_FIRST  = 8'hA5;
  localparam logic [DW-1:0] KEY_SECOND = 8'h5A;

  localparam int unsigned SEL_LSB  = 5;
  localparam int unsigned RUN_BIT  = 2;
  localparam int unsigned FLAG_BIT = 1;
endpackage

// File: rtl/wdog_presc.sv
module wdog_presc #(
  parameter int unsigned BASE  = 4,
  parameter int unsigned SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             clr,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int unsigned PW = BASE + (1 << SEL_W) - 1;

  logic [PW-1:0] pc_q, pc_d;
  logic [PW:0]   lim;

  always_comb begin
    lim  = ({{PW{1'b0}}, 1'b1} << (BASE + int'(sel))) - {{PW{1'b0}}, 1'b1};
    tick = run && ({1'b0, pc_q} >= lim);
    if (clr)       pc_d = '0;
    else if (!run) pc_d = pc_q;
    else if (tick) pc_d = '0;
    else           pc_d = pc_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end
endmodule

// File: rtl/wdog_feed.sv
module wdog_feed
  import wdog_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          feed_ok
);
  logic armed_q, armed_d;
  logic first_wr, second_wr;

  always_comb begin
    first_wr  = we && (addr == ADR_KEY1) && (wdata == KEY_FIRST);
    second_wr = we && (addr == ADR_KEY2) && (wdata == KEY_SECOND);
    feed_ok   = armed_q && second_wr;
    armed_d   = acc ? first_wr : armed_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end
endmodule

// File: rtl/wdog_cnt.sv
module wdog_cnt #(
  parameter int unsigned   W       = 8,
  parameter logic [W-1:0]  RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         feed,
  input  logic [W-1:0] reload,
  output logic [W-1:0] cnt,
  output logic         uf
);
  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    uf = tick && !feed && (cnt_q == '0);
    if (feed)      cnt_d = reload;
    else if (uf)   cnt_d = reload;
    else if (tick) cnt_d = cnt_q - W'(1);
    else           cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= RST_VAL;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/wdog_pulse.sv
module wdog_pulse #(
  parameter int unsigned LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic pulse
);
  localparam int unsigned CW = $clog2(LEN + 1);

  logic [CW-1:0] left_q, left_d;

  always_comb begin
    if (trig)              left_d = CW'(LEN);
    else if (left_q != '0) left_d = left_q - CW'(1);
    else                   left_d = left_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) left_q <= '0;
    else        left_q <= left_d;
  end

  assign pulse = (left_q != '0);
endmodule

// File: rtl/wdog_core.sv
module wdog_core
  import wdog_pkg::*;
#(
  parameter int unsigned    PRESC_BASE = 4,
  parameter int unsigned    RST_LEN    = 4,
  parameter logic [7:0]     RELOAD_RST = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic       reg_re,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       wd_reset
);
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             run_q, run_d;
  logic             flag_q, flag_d;
  logic [DW-1:0]    reload_q, reload_d;
  logic             wr_ctrl, wr_reload;
  logic             tick_w, feed_ok_w, uf_w;
  logic [DW-1:0]    cnt_w;

  always_comb begin
    wr_ctrl   = reg_we && (reg_addr == ADR_CTRL);
    wr_reload = reg_we && (reg_addr == ADR_RELOAD);
    sel_d     = wr_ctrl   ? reg_wdata[SEL_LSB +: SEL_W] : sel_q;
    run_d     = wr_ctrl   ? reg_wdata[RUN_BIT]          : run_q;
    reload_d  = wr_reload ? reg_wdata                   : reload_q;
    if (uf_w)                             flag_d = 1'b1;
    else if (wr_ctrl && !reg_wdata[FLAG_BIT]) flag_d = 1'b0;
    else                                  flag_d = flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= '1;
      run_q    <= 1'b1;
      flag_q   <= 1'b0;
      reload_q <= RELOAD_RST;
    end else begin
      sel_q    <= sel_d;
      run_q    <= run_d;
      flag_q   <= flag_d;
      reload_q <= reload_d;
    end
  end

  wdog_presc #(.BASE(PRESC_BASE), .SEL_W(SEL_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run_q), .clr(feed_ok_w),
    .sel(sel_q), .tick(tick_w)
  );

  wdog_feed u_feed (
    .clk(clk), .rst_n(rst_n), .acc(reg_we || reg_re), .we(reg_we),
    .addr(reg_addr), .wdata(reg_wdata), .feed_ok(feed_ok_w)
  );

  wdog_cnt #(.W(DW), .RST_VAL(RELOAD_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_w), .feed(feed_ok_w),
    .reload(reload_q), .cnt(cnt_w), .uf(uf_w)
  );

  wdog_pulse #(.LEN(RST_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trig(uf_w), .pulse(wd_reset)
  );

  always_comb begin
    unique case (reg_addr)
      ADR_CTRL:   reg_rdata = {sel_q, 2'b00, run_q, flag_q, 1'b0};
      ADR_RELOAD: reg_rdata = reload_q;
      ADR_KEY1:   reg_rdata = cnt_w;
      default:    reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk #(
  parameter int unsigned RST_LEN = 4
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [2:0] sel_q,
  input logic       run_q,
  input logic       flag_q,
  input logic [7:0] reload_q,
  input logic [7:0] cnt,
  input logic       tick,
  input logic       feed_ok,
  input logic       uf,
  input logic       wd_reset
);
  int unsigned since_uf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  since_uf <= RST_LEN + 1;
    else if (uf)                 since_uf <= 0;
    else if (since_uf <= RST_LEN) since_uf <= since_uf + 1;
  end

  assert_pulse_len_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_reset == (since_uf < RST_LEN));

  assert_flag_with_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_reset) |-> flag_q);

  assert_cfg_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (uf && !reg_we) |=> ($stable(sel_q) && $stable(run_q) && $stable(reload_q)));

  assert_hold_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_q && !feed_ok) |=> $stable(cnt));

  assert_no_tick_stopped_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run_q);

  assert_feed_loads_R7: assert property (@(posedge clk) disable iff (!rst_n)
    feed_ok |=> (cnt == $past(reload_q)));
endmodule

bind wdog_core wdog_chk #(.RST_LEN(RST_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .sel_q(sel_q), .run_q(run_q),
  .flag_q(flag_q), .reload_q(reload_q), .cnt(cnt_w), .tick(tick_w),
  .feed_ok(feed_ok_w), .uf(uf_w), .wd_reset(wd_reset)
);

// File: tb/sim_wdog_core.sv
module sim_wdog_core;
  localparam int BASE = 0;
  localparam int LEN  = 4;
  localparam logic [7:0] RVAL = 8'h30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic wd_reset;

  int checks = 0, bad = 0, cycles = 0, hi_seen = 0;

  wdog_core #(.PRESC_BASE(BASE), .RST_LEN(LEN), .RELOAD_RST(RVAL)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_re(re), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .wd_reset(wd_reset)
  );

  always #2 clk = ~clk;

  // behavioural reference state
  int m_pc = 0, m_cnt = RVAL, m_sel = 7, m_run = 1, m_flag = 0, m_rel = RVAL, m_arm = 0, m_left = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0; m_cnt = RVAL; m_sel = 7; m_run = 1; m_flag = 0; m_rel = RVAL; m_arm = 0; m_left = 0;
    end else begin
      bit tk, fd, u;
      int old_rel;
      old_rel = m_rel;
      tk = (m_run == 1) && (m_pc >= (1 << (BASE + m_sel)) - 1);
      fd = (m_arm == 1) && we && addr == 2'd3 && wdata == 8'h5A;
      u  = tk && !fd && m_cnt == 0;
      if (fd) m_pc = 0;
      else if (m_run == 1) m_pc = tk ? 0 : m_pc + 1;
      if (fd || u) m_cnt = old_rel;
      else if (tk) m_cnt = m_cnt - 1;
      if (u) m_left = LEN;
      else if (m_left > 0) m_left = m_left - 1;
      if (u) m_flag = 1;
      else if (we && addr == 2'd0 && !wdata[1]) m_flag = 0;
      if (we && addr == 2'd0) begin m_sel = wdata[7:5]; m_run = wdata[2]; end
      if (we && addr == 2'd1) m_rel = wdata;
      if (we || re) m_arm = (we && addr == 2'd2 && wdata == 8'hA5) ? 1 : 0;
    end
  end

  function automatic int model_rd(input int a);
    case (a)
      0: return (m_sel << 5) | (m_run << 2) | (m_flag << 1);
      1: return m_rel;
      2: return m_cnt;
      default: return 0;
    endcase
  endfunction

  // per-cycle comparison of the reset output (R5)
  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      checks++;
      if (wd_reset !== (m_left != 0)) begin
        bad++;
        $display("FAIL R5 cycle %0d wd_reset actual=%0b expected=%0b", cycles, wd_reset, m_left != 0);
      end
      if (wd_reset) hi_seen++;
    end
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog expired actual=%0d expected<=100000 cycles", cycles);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    @(negedge clk); re = 1'b1; addr = a;
    #1;
    checks++;
    if (rdata !== 8'(model_rd(a))) begin
      bad++;
      $display("FAIL %s read addr %0d actual=%h expected=%h", tag, a, rdata, 8'(model_rd(a)));
    end
    @(posedge clk); #1 re = 1'b0;
  endtask

  task automatic expect_val(input logic [1:0] a, input logic [7:0] e, input string tag);
    @(negedge clk); re = 1'b1; addr = a;
    #1;
    checks++;
    if (rdata !== e) begin
      bad++;
      $display("FAIL %s addr %0d actual=%h expected=%h", tag, a, rdata, e);
    end
    @(posedge clk); #1 re = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    // R1 reset state, R2 map
    expect_val(2'd0, 8'hE4, "R1");
    expect_val(2'd1, RVAL, "R1");
    expect_val(2'd2, RVAL, "R1");
    expect_val(2'd3, 8'h00, "R2");
    wr(2'd1, 8'h06);
    expect_val(2'd1, 8'h06, "R2");
    // select 0, run: feed then watch decrement (R3, R7)
    wr(2'd0, 8'h04);
    wr(2'd2, 8'hA5);
    wr(2'd3, 8'h5A);
    rd(2'd2, "R7");
    idle(2);
    rd(2'd2, "R3");
    // let it underflow (R4, R5, R6)
    idle(12);
    rd(2'd0, "R4");
    rd(2'd1, "R6");
    expect_val(2'd0, 8'h06, "R6");
    // flag handling (R10)
    wr(2'd0, 8'h06);
    rd(2'd0, "R10");
    wr(2'd0, 8'h04);
    rd(2'd0, "R10");
    // stop (R9)
    wr(2'd0, 8'h00);
    rd(2'd2, "R9");
    idle(6);
    rd(2'd2, "R9");
    // select 3 (R3), cancellation cases (R8)
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h64);
    idle(20);
    rd(2'd2, "R3");
    wr(2'd2, 8'hA5); rd(2'd0, "R8"); wr(2'd3, 8'h5A); rd(2'd2, "R8");
    wr(2'd2, 8'hA5); wr(2'd3, 8'h5B); rd(2'd2, "R8");
    wr(2'd2, 8'hA5); wr(2'd1, 8'h40); wr(2'd3, 8'h5A); rd(2'd2, "R8");
    wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
    expect_val(2'd2, 8'h40, "R7");
    // keep alive with select 0: no pulse over the window (R7)
    wr(2'd1, 8'h08);
    wr(2'd0, 8'h04);
    wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
    hi_seen = 0;
    for (int i = 0; i < 15; i++) begin
      idle(3);
      wr(2'd2, 8'hA5); wr(2'd3, 8'h5A);
    end
    checks++;
    if (hi_seen != 0) begin
      bad++;
      $display("FAIL R7 pulses while fed actual=%0d expected=0", hi_seen);
    end
    // stop feeding: back-to-back underflows with reload 0 (R5)
    wr(2'd1, 8'h00);
    idle(30);
    rd(2'd0, "R4");
    wr(2'd0, 8'h00);
    rd(2'd2, "R9");
    idle(8);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule